// File: doc/BRIEF.md
# Programmable Memory Region Address Decoder

This block decides which resource answers a memory access. It selects the SDRAM controller, the PCI bus, the general-purpose bus or one of three ROM chip selects, and it also reports whether the access may be cached and whether it is write-protected. Sixteen programmable windows lie over a default SDRAM space. The default space ends at a configurable top-of-SDRAM limit. Any enabled window takes precedence over that default space. No address translation happens: SDRAM that a window covers is simply unreachable for the CPU.

A lookup is presented with a strobe, a byte address and a flag that says whether the requester is a PCI bus master rather than the CPU. One clock later the result appears with its own valid pulse. Windows are written one at a time through a configuration port. The top-of-SDRAM limit, the SDRAM-present flag and the bus-master SDRAM enable are static inputs from elsewhere in the chip.

Top module: `mem_region_decoder`

## Requirements
- R1: After reset `rsp_valid` is low and every window is disabled, so a CPU lookup below `sdram_top` returns target 0 (SDRAM) with cacheable 1 and write-protect 0.
- R2: A lookup strobed on one rising edge gives `rsp_valid` high for exactly the following cycle. The result outputs keep their value until the next lookup.
- R3: Window i matches when `start*4096 <= addr < start*4096 + (size+1)*G`, with G = 4 KB when `big` is 0 and G = 64 KB when `big` is 1. Target codes are 0 SDRAM, 1 PCI, 2 general-purpose bus, 3/4/5 ROM select 0/1/2. A window with code 6 or 7 never matches. Output code 7 means the access is blocked.
- R4: A lookup that matches no window goes to SDRAM when the address is below `sdram_top` and SDRAM is present. Otherwise it goes to PCI.
- R5: If several enabled windows match, the lowest-numbered one decides the result.
- R6: A window whose target is SDRAM matches only addresses below `sdram_top`. Its portion at or above the limit behaves as if the window were absent.
- R7: With `sdram_en` low, no lookup reports SDRAM. Hits on SDRAM-target windows and misses both go to PCI.
- R8: `cacheable` is 1 only for SDRAM and ROM targets whose matched window (if any) has its noncacheable bit clear. PCI, general-purpose bus and blocked results are never cacheable.
- R9: A CPU lookup that matches a window reports that window's write-protect bit. A lookup on the default space reports 0.
- R10: A bus-master lookup below `sdram_top`, with SDRAM present, that matches a window whose target is not SDRAM is sent to SDRAM with write-protect 1.
- R11: A bus-master lookup whose result would be SDRAM while `mst_sdram_en` is low returns code 7 with cacheable 0 and write-protect 0.
- R12: A window write takes effect for the very next lookup. Clearing a window's enable makes the region underneath visible again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for one window |
| cfg_idx | input | 4 | Window number to write |
| cfg_en | input | 1 | Window enable |
| cfg_tgt | input | 3 | Window target code |
| cfg_wp | input | 1 | Window write-protect bit |
| cfg_nc | input | 1 | Window noncacheable bit |
| cfg_big | input | 1 | Size granule: 0 = 4 KB, 1 = 64 KB |
| cfg_size | input | 7 | Window length in granules minus one |
| cfg_start | input | 20 | Window start address in 4 KB pages |
| sdram_top | input | 32 | Exclusive byte limit of SDRAM space |
| sdram_en | input | 1 | SDRAM is present and enabled |
| mst_sdram_en | input | 1 | Bus masters may reach SDRAM |
| req_valid | input | 1 | Lookup strobe |
| req_addr | input | 32 | Lookup byte address |
| req_master | input | 1 | Lookup comes from a PCI bus master |
| rsp_valid | output | 1 | Result valid, one cycle after the strobe |
| rsp_target | output | 3 | Selected target code |
| rsp_cacheable | output | 1 | Access may be cached |
| rsp_wprot | output | 1 | Access is write-protected |

## Verification
Every result is due on the rising edge after the one that samples `req_valid`, so the bench drives each lookup on a falling edge and reads the outputs on the next falling edge, half a cycle after they were registered. A window write is registered on its own edge. The bench issues the following lookup straight after the write to show that the change applies at once. The hold check reads the outputs one further falling edge later, after an edge with no strobe, and expects them unchanged with `rsp_valid` low.

// File: rtl/mem_region_decoder.sv
module mem_region_decoder #(
  parameter int ADDR_W = 32,
  parameter int NREG   = 16,
  parameter int SIZE_W = 7,
  localparam int IDX_W = $clog2(NREG),
  localparam int PG_W  = ADDR_W - 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_en,
  input  logic [2:0]        cfg_tgt,
  input  logic              cfg_wp,
  input  logic              cfg_nc,
  input  logic              cfg_big,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic [PG_W-1:0]   cfg_start,
  input  logic [ADDR_W-1:0] sdram_top,
  input  logic              sdram_en,
  input  logic              mst_sdram_en,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_master,
  output logic              rsp_valid,
  output logic [2:0]        rsp_target,
  output logic              rsp_cacheable,
  output logic              rsp_wprot
);
  localparam logic [2:0] T_SDRAM = 3'd0;
  localparam logic [2:0] T_PCI   = 3'd1;
  localparam logic [2:0] T_GP    = 3'd2;
  localparam logic [2:0] T_ROM2  = 3'd5;
  localparam logic [2:0] T_BLOCK = 3'd7;

  logic [NREG-1:0]   r_en, r_wp, r_nc, r_big;
  logic [2:0]        r_tgt   [NREG];
  logic [SIZE_W-1:0] r_size  [NREG];
  logic [PG_W-1:0]   r_start [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_en  <= '0;
      r_wp  <= '0;
      r_nc  <= '0;
      r_big <= '0;
      for (int i = 0; i < NREG; i++) begin
        r_tgt[i]   <= '0;
        r_size[i]  <= '0;
        r_start[i] <= '0;
      end
    end else if (cfg_we) begin
      r_en[cfg_idx]    <= cfg_en;
      r_wp[cfg_idx]    <= cfg_wp;
      r_nc[cfg_idx]    <= cfg_nc;
      r_big[cfg_idx]   <= cfg_big;
      r_tgt[cfg_idx]   <= cfg_tgt;
      r_size[cfg_idx]  <= cfg_size;
      r_start[cfg_idx] <= cfg_start;
    end
  end

  logic              below_top;
  logic [ADDR_W:0]   addr_x;
  logic [NREG-1:0]   hit;

  assign below_top = req_addr < sdram_top;
  assign addr_x    = {1'b0, req_addr};

  for (genvar g = 0; g < NREG; g++) begin : g_win
    logic [ADDR_W:0] lo, span, hi;
    logic            in_range, tgt_ok;
    assign lo       = {1'b0, r_start[g], 12'b0};
    assign span     = ({{(ADDR_W+1-SIZE_W){1'b0}}, r_size[g]} + (ADDR_W+1)'(1))
                      << (r_big[g] ? 5'd16 : 5'd12);
    assign hi       = lo + span;
    assign in_range = (addr_x >= lo) && (addr_x < hi);
    assign tgt_ok   = (r_tgt[g] <= T_ROM2) && ((r_tgt[g] != T_SDRAM) || below_top);
    assign hit[g]   = r_en[g] && tgt_ok && in_range;
  end

  logic             win_found;
  logic [IDX_W-1:0] win;
  logic [2:0]       d_tgt;
  logic             d_wp, d_nc, d_cache;

  always_comb begin
    win_found = 1'b0;
    win       = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hit[i]) begin
        win_found = 1'b1;
        win       = IDX_W'(i);
      end
    end
  end

  always_comb begin
    d_tgt = (below_top && sdram_en) ? T_SDRAM : T_PCI;
    d_wp  = 1'b0;
    d_nc  = 1'b0;
    if (win_found) begin
      d_tgt = r_tgt[win];
      d_wp  = r_wp[win];
      d_nc  = r_nc[win];
      if (d_tgt == T_SDRAM && !sdram_en)
        d_tgt = T_PCI;
      if (req_master && sdram_en && below_top && r_tgt[win] != T_SDRAM) begin
        d_tgt = T_SDRAM;
        d_wp  = 1'b1;
      end
    end
    if (req_master && d_tgt == T_SDRAM && !mst_sdram_en) begin
      d_tgt = T_BLOCK;
      d_wp  = 1'b0;
    end
  end

  assign d_cache = !d_nc && (d_tgt == T_SDRAM || (d_tgt > T_GP && d_tgt <= T_ROM2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_target    <= T_SDRAM;
      rsp_cacheable <= 1'b0;
      rsp_wprot     <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_target    <= d_tgt;
        rsp_cacheable <= d_cache;
        rsp_wprot     <= d_wp;
      end
    end
  end
endmodule

module mem_region_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sdram_en,
  input logic       mst_sdram_en,
  input logic       req_valid,
  input logic       req_master,
  input logic       rsp_valid,
  input logic [2:0] rsp_target,
  input logic       rsp_cacheable,
  input logic       rsp_wprot
);
  // R2
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R2
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(rsp_target) && $stable(rsp_cacheable) && $stable(rsp_wprot)));
  // R8
  uncached_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_target == 3'd1 || rsp_target == 3'd2 || rsp_target == 3'd7))
      |-> !rsp_cacheable);
  // R7
  no_sdram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !sdram_en) |=> (rsp_target != 3'd0));
  // R11
  mst_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_master && !mst_sdram_en) |=> (rsp_target != 3'd0));
  // R11
  block_wp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_target == 3'd7) |-> !rsp_wprot);
endmodule

bind mem_region_decoder mem_region_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sdram_en(sdram_en), .mst_sdram_en(mst_sdram_en),
  .req_valid(req_valid), .req_master(req_master), .rsp_valid(rsp_valid),
  .rsp_target(rsp_target), .rsp_cacheable(rsp_cacheable), .rsp_wprot(rsp_wprot)
);

// File: tb/mem_region_decoder_tb.sv
module mem_region_decoder_tb;
  localparam logic [2:0] T_SD = 3'd0, T_PCI = 3'd1, T_GP = 3'd2,
                         T_R0 = 3'd3, T_R1 = 3'd4, T_BLK = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic        cfg_en = 1'b0, cfg_wp = 1'b0, cfg_nc = 1'b0, cfg_big = 1'b0;
  logic [2:0]  cfg_tgt = '0;
  logic [6:0]  cfg_size = '0;
  logic [19:0] cfg_start = '0;
  logic [31:0] sdram_top = 32'h0100_0000;
  logic        sdram_en = 1'b1, mst_sdram_en = 1'b0;
  logic        req_valid = 1'b0, req_master = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_cacheable, rsp_wprot;
  logic [2:0]  rsp_target;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  mem_region_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
    .cfg_tgt(cfg_tgt), .cfg_wp(cfg_wp), .cfg_nc(cfg_nc), .cfg_big(cfg_big),
    .cfg_size(cfg_size), .cfg_start(cfg_start), .sdram_top(sdram_top),
    .sdram_en(sdram_en), .mst_sdram_en(mst_sdram_en), .req_valid(req_valid),
    .req_addr(req_addr), .req_master(req_master), .rsp_valid(rsp_valid),
    .rsp_target(rsp_target), .rsp_cacheable(rsp_cacheable), .rsp_wprot(rsp_wprot)
  );

  task automatic check(string rq, logic [5:0] got, logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got v=%b t=%0d c=%b w=%b, expected v=%b t=%0d c=%b w=%b", rq,
               got[5], got[4:2], got[1], got[0], exp[5], exp[4:2], exp[1], exp[0]);
    end
  endtask

  task automatic wr(int idx, bit en, logic [2:0] tgt, bit wp, bit nc, bit big,
                    int size, logic [19:0] start);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_en = en; cfg_tgt = tgt; cfg_wp = wp;
    cfg_nc = nc; cfg_big = big; cfg_size = 7'(size); cfg_start = start;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic look(string rq, logic [31:0] a, bit m, logic [2:0] et, bit ec, bit ew);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_master = m;
    @(negedge clk);
    req_valid = 1'b0; req_master = 1'b0;
    check(rq, {rsp_valid, rsp_target, rsp_cacheable, rsp_wprot}, {1'b1, et, ec, ew});
  endtask

  task automatic t_reset();
    check("R1", {rsp_valid, 5'b0}, 6'b0);
    look("R1", 32'h0000_1000, 0, T_SD, 1, 0);
  endtask

  task automatic t_timing();
    look("R2", 32'h0000_2000, 0, T_SD, 1, 0);
    @(negedge clk);
    check("R2", {rsp_valid, rsp_target, rsp_cacheable, rsp_wprot}, {1'b0, T_SD, 1'b1, 1'b0});
  endtask

  task automatic t_default();
    look("R4", 32'h00FF_FFFF, 0, T_SD, 1, 0);
    look("R4", 32'h0100_0000, 0, T_PCI, 0, 0);
    look("R4", 32'h0200_0000, 0, T_PCI, 0, 0);
  endtask

  task automatic t_overlay();
    wr(2, 1, T_GP, 0, 0, 0, 15, 20'h000A0);
    look("R12", 32'h000A_8000, 0, T_GP, 0, 0);
    look("R3", 32'h000A_FFFF, 0, T_GP, 0, 0);
    look("R3", 32'h000B_0000, 0, T_SD, 1, 0);
    look("R3", 32'h0009_FFFF, 0, T_SD, 1, 0);
    wr(3, 1, T_R0, 1, 0, 1, 1, 20'h03000);
    look("R9", 32'h0301_F000, 0, T_R0, 1, 1);
    look("R3", 32'h0302_0000, 0, T_PCI, 0, 0);
    wr(6, 1, 3'd6, 0, 0, 0, 0, 20'h00500);
    look("R3", 32'h0050_0000, 0, T_SD, 1, 0);
  endtask

  task automatic t_priority();
    wr(1, 1, T_R1, 0, 1, 0, 0, 20'h000A4);
    wr(5, 1, T_PCI, 0, 0, 0, 0, 20'h000A4);
    look("R5", 32'h000A_4800, 0, T_R1, 0, 0);
    look("R8", 32'h000A_5000, 0, T_GP, 0, 0);
  endtask

  task automatic t_clip();
    wr(4, 1, T_SD, 0, 1, 0, 3, 20'h00FFE);
    look("R6", 32'h00FF_F000, 0, T_SD, 0, 0);
    look("R6", 32'h0100_0000, 0, T_PCI, 0, 0);
  endtask

  task automatic t_nosdram();
    sdram_en = 1'b0;
    look("R7", 32'h00FF_F000, 0, T_PCI, 0, 0);
    look("R7", 32'h0000_1000, 0, T_PCI, 0, 0);
    sdram_en = 1'b1;
  endtask

  task automatic t_master();
    mst_sdram_en = 1'b0;
    look("R11", 32'h0000_1000, 1, T_BLK, 0, 0);
    look("R11", 32'h000A_8000, 1, T_BLK, 0, 0);
    mst_sdram_en = 1'b1;
    look("R10", 32'h0000_1000, 1, T_SD, 1, 0);
    look("R10", 32'h000A_8000, 1, T_SD, 1, 1);
    look("R10", 32'h0301_0000, 1, T_R0, 1, 1);
    look("R10", 32'h0200_0000, 1, T_PCI, 0, 0);
    mst_sdram_en = 1'b0;
  endtask

  task automatic t_reconfig();
    wr(2, 0, T_GP, 0, 0, 0, 15, 20'h000A0);
    look("R12", 32'h000A_8000, 0, T_SD, 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timing();
    t_default();
    t_overlay();
    t_priority();
    t_clip();
    t_nosdram();
    t_master();
    t_reconfig();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule